// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block is a small, fully associative translation cache shared by instruction fetch and data access. Each of its entries maps one virtual page to a physical page, and each entry carries its own page size: 1 MB, 64 KB, 4 KB or 1 KB. A requester presents a virtual address together with a write flag and a user-mode flag. The block answers with a hit or miss indication, the translated physical address, the cacheable and bufferable attribute bits of the mapping, and a flag that reports a permission violation.

When a lookup misses, the request is held and a walk request is raised toward an external table walker. The walker answers through the fill port, which writes the chosen victim entry. One cycle after that write, the held lookup is retried. Fills may also arrive at any other time to preload mappings.

A control port clears every entry, or only the entries that cover a given address. A lockdown base index protects the entries below it from replacement. For 64 KB and 4 KB pages, each quarter of the page has its own access-permission field.

Top module: `tlb_multisize`

## Requirements
- R1: After reset every entry is invalid, the victim pointer is 0, `lkReady` is 1, and `lkDone` and `walkReq` are 0.
- R2: A lookup is accepted on a clock edge where `lkValid` and `lkReady` are both 1. `lkDone` is 1 for exactly the following cycle, and `lkReady` is 0 during that cycle.
- R3: The page size is encoded on `fillSize` as 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 1 KB. These sizes give 20, 16, 12 and 10 offset bits. An entry hits when the address bits above its offset equal its stored tag. The physical address is then the stored physical page above the offset, joined with the request's own offset bits.
- R4: A miss shows `lkDone` = 1 with `lkHit` = 0. From the next cycle on, `walkReq` is 1 and `walkVa` carries the held address, until a cycle with `fillValid`. The retried result appears on `lkDone` in the cycle after that fill edge.
- R5: `fillAp` holds four 2-bit fields, with field q at bits 2q+1:2q. A 64 KB page selects its field with address bits 15:14, and a 4 KB page selects with bits 11:10. A 1 MB or 1 KB page always uses field 0.
- R6: The permission codes are 00 = no access, 01 = privileged only, 10 = user read-only, 11 = full access. A disallowed access gives `lkHit` = 1 and `lkFault` = 1, and forces `lkPa`, `lkCache` and `lkBuf` to 0.
- R7: On an allowed hit, `lkCache` and `lkBuf` return the bits stored with the entry. On a miss they are 0.
- R8: A cycle with `invAll` = 1 makes every entry invalid at that edge, including one written by a fill at the same edge.
- R9: A cycle with `invByVa` = 1 clears only the valid entries whose tag matches `invVpn` under that entry's own size. Other entries are unaffected.
- R10: Each fill writes the victim entry. The victim is the round-robin pointer, or `lockBase` if the pointer is below `lockBase`. The pointer then moves to the victim plus one, and wraps from the last entry back to `lockBase`. Entries below `lockBase` are never replaced.
- R11: When several entries hit, the entry with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request |
| lkVa | input | VA_W | Lookup virtual address |
| lkWrite | input | 1 | Access is a write |
| lkUser | input | 1 | Access is from user mode |
| lkReady | output | 1 | A lookup can be accepted |
| lkDone | output | 1 | Lookup result is valid this cycle |
| lkHit | output | 1 | The result hit an entry |
| lkFault | output | 1 | The hit violated its permission |
| lkPa | output | VA_W | Physical address (zero on a miss or a fault) |
| lkCache | output | 1 | Cacheable attribute |
| lkBuf | output | 1 | Bufferable attribute |
| walkReq | output | 1 | A table walk is needed for walkVa |
| walkVa | output | VA_W | Address of the pending walk |
| fillValid | input | 1 | Write one entry this cycle |
| fillVpn | input | VA_W-10 | Virtual page bits 31:10 of the new mapping |
| fillPpn | input | VA_W-10 | Physical page bits 31:10 of the new mapping |
| fillSize | input | 2 | Page size code |
| fillAp | input | 8 | Four permission fields |
| fillC | input | 1 | Cacheable bit |
| fillB | input | 1 | Bufferable bit |
| invAll | input | 1 | Invalidate every entry |
| invByVa | input | 1 | Invalidate entries that cover invVpn |
| invVpn | input | VA_W-10 | Address bits 31:10 for the selective invalidate |
| lockBase | input | clog2(ENTRIES) | First index that replacement may use |

## Verification
A lookup that hits returns its result on `lkDone` in the cycle after the edge that accepts it. A miss returns its miss result in that same cycle, and `walkReq` then holds from the following cycle until a fill edge, after which the retried result lands one cycle later. Fills and invalidates change the entries at their own edge, so they affect a result that is visible in the next cycle. The bench keeps a behavioural model whose state advances on every rising edge from the same inputs. At each falling edge it compares every output against that model, so each result is checked in exactly the cycle it is due. A few explicit checks on hand-computed addresses sit alongside this comparison.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Smallest page is 1 KB: bits below this are never translated.
  localparam int MIN_OFS = 10;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,  // 1 MB
    PG_LARGE   = 2'd1,  // 64 KB, four subpage fields
    PG_SMALL   = 2'd2,  // 4 KB, four subpage fields
    PG_TINY    = 2'd3   // 1 KB
  } pageSize_e;

  typedef struct packed {
    logic loadReq;     // capture a new lookup request
    logic showResult;  // drive the lookup result onto the outputs
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lkValid,
  input  logic       anyHit,
  input  logic       fillValid,
  output tlbStrobe_t strobe,
  output logic       lkReady,
  output logic       lkDone,
  output logic       walkReq
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WALK} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (lkValid)   stateNext = ST_LOOK;
      ST_LOOK: stateNext = anyHit ? ST_IDLE : ST_WALK;
      ST_WALK: if (fillValid) stateNext = ST_LOOK;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign lkReady           = (state == ST_IDLE);
  assign lkDone            = (state == ST_LOOK);
  assign walkReq           = (state == ST_WALK);
  assign strobe.loadReq    = lkReady && lkValid;
  assign strobe.showResult = lkDone;
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VPN_W  = VA_W - MIN_OFS
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [VA_W-1:0]  lkVa,
  input  logic             lkWrite,
  input  logic             lkUser,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [VPN_W-1:0] fillPpn,
  input  logic [1:0]       fillSize,
  input  logic [7:0]       fillAp,
  input  logic             fillC,
  input  logic             fillB,
  input  logic             invAll,
  input  logic             invByVa,
  input  logic [VPN_W-1:0] invVpn,
  input  logic [IDX_W-1:0] lockBase,
  output logic             anyHit,
  output logic             lkHit,
  output logic             lkFault,
  output logic [VA_W-1:0]  lkPa,
  output logic             lkCache,
  output logic             lkBuf,
  output logic [VA_W-1:0]  walkVa
);
  // Mask over the page-number bits that a page of size s compares.
  function automatic logic [VPN_W-1:0] sizeMask(pageSize_e s);
    logic [VPN_W-1:0] one;
    int lowBits;
    one = VPN_W'(1);
    unique case (s)
      PG_SECTION: lowBits = 20 - MIN_OFS;
      PG_LARGE:   lowBits = 16 - MIN_OFS;
      PG_SMALL:   lowBits = 12 - MIN_OFS;
      default:    lowBits = 0;
    endcase
    return ~((one << lowBits) - one);
  endfunction

  logic [ENTRIES-1:0] vld, vldNext, hitVec, invHit;
  logic [VPN_W-1:0]   tagQ   [ENTRIES];
  logic [VPN_W-1:0]   pbaseQ [ENTRIES];
  pageSize_e          sizeQ  [ENTRIES];
  logic [7:0]         apQ    [ENTRIES];
  logic [ENTRIES-1:0] cQ, bQ;
  logic [IDX_W-1:0]   rr, victim, rrNext;

  logic [VA_W-1:0] reqVa;
  logic            reqWrite, reqUser;
  wire  [VPN_W-1:0] reqVpn = reqVa[VA_W-1:MIN_OFS];

  // Request register: held for the whole miss/walk sequence.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqVa    <= '0;
      reqWrite <= 1'b0;
      reqUser  <= 1'b0;
    end else if (strobe.loadReq) begin
      reqVa    <= lkVa;
      reqWrite <= lkWrite;
      reqUser  <= lkUser;
    end
  end

  // Per-entry matching under each entry's own size mask.
  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    wire [VPN_W-1:0] m = sizeMask(sizeQ[g]);
    assign hitVec[g] = vld[g] && (((tagQ[g] ^ reqVpn) & m) == '0);
    assign invHit[g] = vld[g] && (((tagQ[g] ^ invVpn) & m) == '0);
    always_comb begin
      vldNext[g] = vld[g];
      if (fillValid && victim == IDX_W'(g)) vldNext[g] = 1'b1;
      if (invAll || (invByVa && invHit[g])) vldNext[g] = 1'b0;
    end
  end

  // Round-robin victim limited to the unlocked range.
  assign victim = (rr < lockBase) ? lockBase : rr;
  assign rrNext = (victim == IDX_W'(ENTRIES - 1)) ? lockBase : victim + IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      rr  <= '0;
      cQ  <= '0;
      bQ  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]   <= '0;
        pbaseQ[i] <= '0;
        sizeQ[i]  <= PG_SECTION;
        apQ[i]    <= '0;
      end
    end else begin
      vld <= vldNext;
      if (fillValid) begin
        tagQ[victim]   <= fillVpn;
        pbaseQ[victim] <= fillPpn;
        sizeQ[victim]  <= pageSize_e'(fillSize);
        apQ[victim]    <= fillAp;
        cQ[victim]     <= fillC;
        bQ[victim]     <= fillB;
        rr             <= rrNext;
      end
    end
  end

  // Lowest-index hit wins.
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hitVec[i]) selIdx = IDX_W'(i);
  end

  // Subpage permission selection and check.
  logic [1:0] quarter, apField;
  logic       deny;
  always_comb begin
    unique case (sizeQ[selIdx])
      PG_LARGE: quarter = reqVa[15:14];
      PG_SMALL: quarter = reqVa[11:10];
      default:  quarter = 2'd0;
    endcase
    apField = apQ[selIdx][{quarter, 1'b0} +: 2];
    unique case (apField)
      2'b00:   deny = 1'b1;
      2'b01:   deny = reqUser;
      2'b10:   deny = reqUser && reqWrite;
      default: deny = 1'b0;
    endcase
  end

  wire [VPN_W-1:0] selMask = sizeMask(sizeQ[selIdx]);
  wire [VPN_W-1:0] paVpn   = (pbaseQ[selIdx] & selMask) | (reqVpn & ~selMask);
  wire             grant   = strobe.showResult && anyHit && !deny;

  assign anyHit  = |hitVec;
  assign lkHit   = strobe.showResult && anyHit;
  assign lkFault = strobe.showResult && anyHit && deny;
  assign lkPa    = grant ? {paVpn, reqVa[MIN_OFS-1:0]} : '0;
  assign lkCache = grant && cQ[selIdx];
  assign lkBuf   = grant && bQ[selIdx];
  assign walkVa  = reqVa;
endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lkValid,
  input  logic [VA_W-1:0]            lkVa,
  input  logic                       lkWrite,
  input  logic                       lkUser,
  output logic                       lkReady,
  output logic                       lkDone,
  output logic                       lkHit,
  output logic                       lkFault,
  output logic [VA_W-1:0]            lkPa,
  output logic                       lkCache,
  output logic                       lkBuf,
  output logic                       walkReq,
  output logic [VA_W-1:0]            walkVa,
  input  logic                       fillValid,
  input  logic [VA_W-MIN_OFS-1:0]    fillVpn,
  input  logic [VA_W-MIN_OFS-1:0]    fillPpn,
  input  logic [1:0]                 fillSize,
  input  logic [7:0]                 fillAp,
  input  logic                       fillC,
  input  logic                       fillB,
  input  logic                       invAll,
  input  logic                       invByVa,
  input  logic [VA_W-MIN_OFS-1:0]    invVpn,
  input  logic [$clog2(ENTRIES)-1:0] lockBase
);
  tlbStrobe_t strobe;
  logic       anyHit;

  tlb_control uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .anyHit(anyHit),
    .fillValid(fillValid), .strobe(strobe), .lkReady(lkReady),
    .lkDone(lkDone), .walkReq(walkReq)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .VA_W(VA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lkVa(lkVa), .lkWrite(lkWrite), .lkUser(lkUser),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillSize(fillSize), .fillAp(fillAp), .fillC(fillC), .fillB(fillB),
    .invAll(invAll), .invByVa(invByVa), .invVpn(invVpn), .lockBase(lockBase),
    .anyHit(anyHit), .lkHit(lkHit), .lkFault(lkFault), .lkPa(lkPa),
    .lkCache(lkCache), .lkBuf(lkBuf), .walkVa(walkVa)
  );
endmodule

// File: rtl/tlb_multisize_chk.sv
module tlb_multisize_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic            lkReady,
  input logic            lkDone,
  input logic            lkHit,
  input logic            lkFault,
  input logic [VA_W-1:0] lkPa,
  input logic            lkCache,
  input logic            lkBuf,
  input logic            walkReq,
  input logic            fillValid,
  input logic            invAll
);
  // R2: accepted lookup produces a result next cycle, not a new accept
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && lkReady |=> lkDone && !lkReady);

  // R2, R4: a result only follows an accept or a fill during a walk
  assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    lkDone |-> $past(lkValid && lkReady) || $past(walkReq && fillValid));

  // R4: walk request starts only after a reported miss
  assert_walk_after_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(walkReq) |-> $past(lkDone && !lkHit));

  // R4: walk request holds until a fill arrives
  assert_walk_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && !fillValid |=> walkReq);

  // R6: a fault carries a hit and no address or attributes
  assert_fault_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    lkFault |-> lkHit && lkPa == '0 && !lkCache && !lkBuf);

  // R7: a miss returns no attributes
  assert_miss_blank_R7: assert property (@(posedge clk) disable iff (!rstN)
    lkDone && !lkHit |-> !lkCache && !lkBuf && lkPa == '0);

  // R8: after invalidate-all, nothing can hit
  assert_flush_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    lkDone && $past(invAll) |-> !lkHit);

  // R2: hit is only reported with a result
  assert_hit_in_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkDone);
endmodule

bind tlb_multisize tlb_multisize_chk #(.VA_W(VA_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkReady(lkReady),
  .lkDone(lkDone), .lkHit(lkHit), .lkFault(lkFault), .lkPa(lkPa),
  .lkCache(lkCache), .lkBuf(lkBuf), .walkReq(walkReq),
  .fillValid(fillValid), .invAll(invAll)
);

// File: tb/tlb_multisize_test.sv
`timescale 1ns/1ps
module tlb_multisize_test;
  localparam int N = 8;
  localparam int SZ_SEC = 0, SZ_LG = 1, SZ_SM = 2, SZ_TINY = 3;

  logic clk = 0, rstN = 0;
  logic lkValid = 0, lkWrite = 0, lkUser = 0;
  logic [31:0] lkVa = 0;
  logic lkReady, lkDone, lkHit, lkFault, lkCache, lkBuf, walkReq;
  logic [31:0] lkPa, walkVa;
  logic fillValid = 0, fillC = 0, fillB = 0;
  logic [21:0] fillVpn = 0, fillPpn = 0, invVpn = 0;
  logic [1:0] fillSize = 0;
  logic [7:0] fillAp = 0;
  logic invAll = 0, invByVa = 0;
  logic [2:0] lockBase = 0;

  int tests = 0, fails = 0, cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;  // 50 MHz

  tlb_multisize uut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa), .lkWrite(lkWrite),
    .lkUser(lkUser), .lkReady(lkReady), .lkDone(lkDone), .lkHit(lkHit),
    .lkFault(lkFault), .lkPa(lkPa), .lkCache(lkCache), .lkBuf(lkBuf),
    .walkReq(walkReq), .walkVa(walkVa), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillSize(fillSize), .fillAp(fillAp), .fillC(fillC),
    .fillB(fillB), .invAll(invAll), .invByVa(invByVa), .invVpn(invVpn),
    .lockBase(lockBase)
  );

  // ---------------- behavioural reference model ----------------
  bit          mV [N];
  logic [31:0] mTag [N], mPa [N];
  int          mSize [N];
  logic [7:0]  mAp [N];
  bit          mC [N], mB [N];
  int          mState = 0, mRr = 0;   // 0 idle, 1 result, 2 walking
  logic [31:0] mReqVa = 0;
  bit          mW = 0, mU = 0;

  function automatic int offs(int s);
    case (s) 0: return 20; 1: return 16; 2: return 12; default: return 10; endcase
  endfunction

  function automatic bit covers(int i, logic [31:0] va);
    int o = offs(mSize[i]);
    return mV[i] && ((va >> o) == (mTag[i] >> o));
  endfunction

  function automatic int mFind(logic [31:0] va);
    for (int i = 0; i < N; i++) if (covers(i, va)) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
      mState = 0; mRr = 0; mReqVa = 0;
    end else begin
      int h, v;
      bit kill [N];
      h = mFind(mReqVa);
      for (int i = 0; i < N; i++) kill[i] = invAll || (invByVa && covers(i, {invVpn, 10'b0}));
      case (mState)
        0: if (lkValid) begin mReqVa = lkVa; mW = lkWrite; mU = lkUser; mState = 1; end
        1: mState = (h >= 0) ? 0 : 2;
        default: if (fillValid) mState = 1;
      endcase
      if (fillValid) begin
        v = (mRr < int'(lockBase)) ? int'(lockBase) : mRr;
        mV[v] = 1; mTag[v] = {fillVpn, 10'b0}; mPa[v] = {fillPpn, 10'b0};
        mSize[v] = int'(fillSize); mAp[v] = fillAp; mC[v] = fillC; mB[v] = fillB;
        mRr = (v == N - 1) ? int'(lockBase) : v + 1;
      end
      for (int i = 0; i < N; i++) if (kill[i]) mV[i] = 0;
    end
  end

  // Compare every output against the model on every cycle.
  always @(negedge clk) begin
    if (rstN) begin
      bit eHit, eFault, eC, eB, ok;
      logic [31:0] ePa;
      int h, o, q;
      logic [1:0] ap;
      eHit = 0; eFault = 0; eC = 0; eB = 0; ePa = 0;
      if (mState == 1) begin
        h = mFind(mReqVa);
        if (h >= 0) begin
          o = offs(mSize[h]);
          q = (mSize[h] == SZ_LG) ? int'(mReqVa[15:14]) :
              (mSize[h] == SZ_SM) ? int'(mReqVa[11:10]) : 0;
          ap = mAp[h][2*q +: 2];
          ok = mU ? (ap == 2'b11 || (ap == 2'b10 && !mW)) : (ap != 2'b00);
          eHit = 1; eFault = !ok;
          if (ok) begin
            ePa = ((mPa[h] >> o) << o) | (mReqVa & ((32'd1 << o) - 32'd1));
            eC = mC[h]; eB = mB[h];
          end
        end
      end
      tests++;
      if (lkReady !== (mState == 0) || lkDone !== (mState == 1) || walkReq !== (mState == 2) ||
          (mState == 2 && walkVa !== mReqVa) || lkHit !== eHit || lkFault !== eFault ||
          lkPa !== ePa || lkCache !== eC || lkBuf !== eB) begin
        fails++;
        $display("FAIL %s t=%0t: rdy/done/walk/hit/flt/c/b pa walkVa got %b%b%b%b%b%b%b %h %h exp %b%b%b%b%b%b%b %h %h",
                 phase, $time, lkReady, lkDone, walkReq, lkHit, lkFault, lkCache, lkBuf, lkPa, walkVa,
                 mState == 0, mState == 1, mState == 2, eHit, eFault, eC, eB, ePa, mReqVa);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input int sz,
                      input logic [7:0] ap, input bit c, input bit b);
    @(posedge clk); #2;
    fillValid = 1; fillVpn = va[31:10]; fillPpn = pa[31:10];
    fillSize = 2'(sz); fillAp = ap; fillC = c; fillB = b;
    @(posedge clk); #2;
    fillValid = 0;
    @(negedge clk);
  endtask

  // Lookup; on a miss, answer the walk with the given mapping.
  task automatic access(input logic [31:0] va, input bit w, input bit u,
                        input logic [31:0] pa, input int sz, input logic [7:0] ap);
    @(posedge clk); #2;
    lkValid = 1; lkVa = va; lkWrite = w; lkUser = u;
    @(posedge clk); #2;
    lkValid = 0;
    @(negedge clk);
    if (!lkHit) fill(va, pa, sz, ap, 1'b0, 1'b0);
  endtask

  task automatic pulseInv(input bit all, input logic [31:0] va);
    @(posedge clk); #2;
    invAll = all; invByVa = !all; invVpn = va[31:10];
    @(posedge clk); #2;
    invAll = 0; invByVa = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    check(lkReady && !lkDone && !walkReq, "R1 reset state", {29'd0, lkReady, lkDone, walkReq}, 32'h4);

    phase = "R2 R4 first miss";
    @(posedge clk); #2;
    lkValid = 1; lkVa = 32'h1234_5678; lkWrite = 0; lkUser = 0;
    @(posedge clk); #2; lkValid = 0;
    @(negedge clk);
    check(lkDone && !lkHit && !lkReady, "R4 miss reported", {30'd0, lkDone, lkHit}, 32'h2);
    @(negedge clk);
    check(walkReq && walkVa == 32'h1234_5678, "R4 walk address", walkVa, 32'h1234_5678);
    phase = "R3 R7 small fill";
    @(posedge clk); #2;
    fillValid = 1; fillVpn = 22'(32'h1234_5678 >> 10); fillPpn = 22'(32'hABCD_E000 >> 10);
    fillSize = 2'(SZ_SM); fillAp = 8'hFF; fillC = 1; fillB = 0;
    @(posedge clk); #2; fillValid = 0;
    @(negedge clk);
    check(lkDone && lkHit && lkPa == 32'hABCD_E678, "R3 small page address", lkPa, 32'hABCD_E678);
    check(lkCache && !lkBuf, "R7 attributes", {30'd0, lkCache, lkBuf}, 32'h2);

    phase = "R3 sizes";
    fill(32'h0030_0000, 32'h8000_0000, SZ_SEC,  8'h03, 0, 1);
    fill(32'h0101_0000, 32'h4002_0000, SZ_LG,   8'b00_01_10_11, 1, 1);
    fill(32'h0200_0400, 32'h6000_0800, SZ_TINY, 8'h02, 0, 0);
    access(32'h003A_BCDE, 0, 0, 0, SZ_SEC, 0);
    check(lkPa == 32'h800A_BCDE, "R3 section address", lkPa, 32'h800A_BCDE);
    phase = "R7 section attributes";
    check(!lkCache && lkBuf, "R7 section bits", {30'd0, lkCache, lkBuf}, 32'h1);
    phase = "R3 large";
    access(32'h0101_1234, 0, 1, 0, SZ_SEC, 0);
    check(lkPa == 32'h4002_1234, "R3 large address", lkPa, 32'h4002_1234);
    phase = "R3 tiny";
    access(32'h0200_07FF, 0, 1, 0, SZ_SEC, 0);
    check(lkPa == 32'h6000_0BFF, "R3 tiny address", lkPa, 32'h6000_0BFF);
    access(32'h0200_0800, 0, 0, 32'h7000_0000, SZ_TINY, 8'hFF);

    phase = "R5 R6 large quarters";
    access(32'h0101_4000, 0, 1, 0, SZ_SEC, 0);
    check(!lkFault, "R5 quarter1 user read", {31'd0, lkFault}, 0);
    access(32'h0101_8000, 0, 1, 0, SZ_SEC, 0);
    check(lkFault && lkPa == 0, "R6 quarter2 user read", lkPa, 0);
    access(32'h0101_C000, 0, 0, 0, SZ_SEC, 0);
    check(lkFault, "R6 quarter3 no access", {31'd0, lkFault}, 1);
    phase = "R5 R6 small quarters";
    fill(32'h0050_0000, 32'h5000_0000, SZ_SM, 8'b11_10_01_00, 0, 0);
    access(32'h0050_0C00, 1, 1, 0, SZ_SEC, 0);
    access(32'h0050_0800, 1, 1, 0, SZ_SEC, 0);
    check(lkFault, "R6 user write read-only", {31'd0, lkFault}, 1);
    access(32'h0050_0400, 1, 0, 0, SZ_SEC, 0);
    access(32'h0050_0400, 0, 1, 0, SZ_SEC, 0);
    access(32'h0050_0000, 0, 0, 0, SZ_SEC, 0);
    phase = "R6 tiny";
    access(32'h0200_0400, 1, 1, 0, SZ_SEC, 0);
    access(32'h0200_0400, 0, 1, 0, SZ_SEC, 0);

    phase = "R11 overlap";
    fill(32'h0034_5000, 32'h9000_0000, SZ_SM, 8'hFF, 1, 0);
    access(32'h0034_5010, 0, 0, 0, SZ_SEC, 0);
    check(lkPa == 32'h8004_5010, "R11 lowest index wins", lkPa, 32'h8004_5010);

    phase = "R10 lockdown";
    @(posedge clk); #2 lockBase = 3'd4;
    fill(32'h0A00_0000, 32'hA000_0000, SZ_SEC, 8'hFF, 0, 0);
    fill(32'h0B00_0000, 32'hB000_0000, SZ_SEC, 8'hFF, 0, 0);
    fill(32'h0C00_0000, 32'hC000_0000, SZ_SEC, 8'hFF, 0, 0);
    access(32'h0050_0C00, 0, 0, 32'h5000_0000, SZ_SM, 8'hFF);
    access(32'h1234_5678, 0, 0, 0, SZ_SEC, 0);
    check(lkPa == 32'hABCD_E678, "R10 locked entry kept", lkPa, 32'hABCD_E678);
    access(32'h0200_0800, 0, 0, 32'h7000_0000, SZ_TINY, 8'hFF);
    for (int k = 0; k < 6; k++) fill(32'h2000_0000 + k * 32'h0010_0000, 32'h3000_0000, SZ_SEC, 8'hFF, 0, 0);
    access(32'h0101_1234, 0, 0, 32'h4002_0000, SZ_LG, 8'hFF);

    phase = "R8 flush";
    pulseInv(1, 0);
    access(32'h1234_5678, 0, 0, 32'hABCD_E000, SZ_SM, 8'hFF);
    access(32'h1234_5678, 0, 0, 0, SZ_SEC, 0);

    phase = "R9 selective";
    fill(32'h0030_0000, 32'h8000_0000, SZ_SEC, 8'hFF, 0, 1);
    fill(32'h0040_1000, 32'h8800_0000, SZ_SM, 8'hFF, 1, 1);
    pulseInv(0, 32'h0077_7000);
    pulseInv(0, 32'h003F_FFFF);
    access(32'h0040_1ABC, 0, 0, 0, SZ_SEC, 0);
    check(lkHit, "R9 other entry kept", {31'd0, lkHit}, 1);
    access(32'h0030_0000, 0, 0, 32'h8100_0000, SZ_SEC, 8'hFF);
    access(32'h1234_5678, 0, 0, 0, SZ_SEC, 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule